// File: doc/BRIEF.md
# Serial Clock and Chip-Select Framing Generator

This block produces the serial clock and chip-select framing for one transfer to one of several attached slave devices. Every device has a 32-bit parameter word and a clock polarity and phase bit of its own. A write-only register port loads these values, together with the index of the device that the next transfer addresses. A start pulse captures the selected device's settings and the number of bits to move. The block then runs a fixed sequence: chip-select assert, setup wait, active clocking, hold wait, chip-select release, and an idle gap. A one-cycle done pulse closes the sequence.

The bit rate comes from a phase accumulator. Each input cycle it adds the device's rate field, rounded down to a power of two, modulo 256. Every wrap is one half-period of the serial clock, so the clock runs at the input clock times the field over 512. That gives a range from one quarter of the input clock down to 1/512 of it. A companion shifter does not need to decode the clock itself. It receives a sample strobe and a shift strobe that coincide with the clock edges the selected clock phase calls for. The block moves no data.

Top module: `spi_tgen`

## Requirements
- R1: The parameter word for device n (n < NUM_DEV, at most 5) is written at byte address 4*n.
  - Bits 31:24 of the word hold the rate field F, bits 23:16 the setup count S, bits 15:8 the hold count Hd, and bits 7:0 the gap count D.
  - The port register sits at byte address 4*NUM_DEV. Its bits 22:20 select the device, bit 19-n holds device n's clock polarity, and bit 14-n holds its clock phase.
- R2: The rate field is rounded down to a power of two P, and F=0 is treated as P=1. During clocking the serial clock toggles every H = 256/P input cycles.
- R3: While no transfer is running, sclk equals the polarity bit of the currently selected device.
- R4: A start pulse is ignored if a transfer is already running or if the device select is NUM_DEV or more. Ignoring it means no chip-select, no clocking and no done.
- R5: cs_n is active-low and one-hot. Only the captured device's bit is low, from the cycle after the accepted start until the hold phase ends. All other bits stay high throughout.
- R6: Take the cycle right after the accepted start edge as cycle 1. The first serial clock toggle appears in cycle S+2+H.
- R7: A transfer of N bits gives exactly 2N clock toggles. The last one returns sclk to the polarity level, and sclk_en is high for exactly 2NH cycles.
- R8: With phase 0, sample_stb marks the leading (odd-numbered) toggles and shift_stb the trailing ones. With phase 1 the roles swap. Each strobe is one cycle wide, appears in the same cycle as its toggle, and occurs N times per transfer.
- R9: cs_n of the captured device returns high in cycle S+2NH+Hd+3.
- R10: done is a one-cycle pulse in cycle S+2NH+Hd+D+4. busy is high from cycle 1 up to that cycle and low in it.
- R11: A transfer with N=0 still runs its setup, hold and gap phases, with no toggles and no strobes, and R9 and R10 apply with N=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register byte address |
| wr_data | input | 32 | Register write data |
| start | input | 1 | Begin a transfer to the selected device |
| nbits | input | CNT_W | Number of bits in the transfer |
| busy | output | 1 | A transfer sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| sclk | output | 1 | Serial clock |
| sclk_en | output | 1 | Active clocking phase in progress |
| sample_stb | output | 1 | Shifter should sample input data |
| shift_stb | output | 1 | Shifter should drive the next output bit |
| cs_n | output | NUM_DEV | One-hot active-low chip selects |

## Verification
All results are counted in cycles from the input edge that accepts start. Chip-select falls in cycle 1, the first toggle is due in cycle S+2+H, chip-select rises in cycle S+2NH+Hd+3, and done follows D+1 cycles after that. The bench drives and samples on the falling clock edge, numbers every cycle after the start edge, and records where each event occurs. It then compares those cycle numbers with the formulas above, recomputed from the field values. The rate field is swept over all 256 values, and device, polarity and phase are swept over every combination.

// File: rtl/spi_tgen_pkg.sv
package spi_tgen_pkg;

  localparam int FLD_W = 8;   // width of every per-device field
  localparam int ACC_W = 8;   // half-period accumulator, modulo 2**ACC_W
  localparam int SEL_W = 3;   // device select field width

  typedef struct packed {
    logic [FLD_W-1:0] rate;
    logic [FLD_W-1:0] setup;
    logic [FLD_W-1:0] hold;
    logic [FLD_W-1:0] gap;
  } dev_param_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_HOLD,
    ST_GAP
  } tgen_state_e;

  // Highest set bit of the rate field survives; zero maps to one.
  function automatic logic [FLD_W-1:0] pow2_floor(input logic [FLD_W-1:0] f);
    logic [FLD_W-1:0] r;
    r = FLD_W'(1);
    for (int i = 0; i < FLD_W; i++) begin
      if (f[i]) r = FLD_W'(1) << i;
    end
    return r;
  endfunction

  // Selected polarity or phase bit out of a per-device vector.
  function automatic logic pick_bit(input logic [7:0] vec, input logic [SEL_W-1:0] idx);
    return vec[idx];
  endfunction

endpackage

// File: rtl/spi_tgen_regs.sv
module spi_tgen_regs
  import spi_tgen_pkg::*;
#(
  parameter int NUM_DEV = 5,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  output dev_param_t         sel_param,
  output logic [SEL_W-1:0]   sel_idx,
  output logic               sel_valid,
  output logic               sel_pol,
  output logic               sel_pha
);

  localparam int PORT_ADDR = 4 * NUM_DEV;
  localparam int SEL_LSB   = 20;
  localparam int POL_TOP   = 19;
  localparam int PHA_TOP   = 14;

  dev_param_t         param_q [NUM_DEV];
  logic [7:0]         pol_vec, pha_vec;
  logic [SEL_W-1:0]   sel_q;
  logic               port_wr;

  assign port_wr = wr_en && (wr_addr == ADDR_W'(PORT_ADDR));

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    logic pol_q, pha_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        param_q[i] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(4 * i))) begin
        param_q[i] <= dev_param_t'(wr_data);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pol_q <= 1'b0;
        pha_q <= 1'b0;
      end else if (port_wr) begin
        pol_q <= wr_data[POL_TOP - i];
        pha_q <= wr_data[PHA_TOP - i];
      end
    end

    assign pol_vec[i] = pol_q;
    assign pha_vec[i] = pha_q;
  end

  for (genvar j = NUM_DEV; j < 8; j++) begin : g_pad
    assign pol_vec[j] = 1'b0;
    assign pha_vec[j] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= '0;
    else if (port_wr) sel_q <= wr_data[SEL_LSB +: SEL_W];
  end

  always_comb begin
    sel_param = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (sel_q == SEL_W'(i)) sel_param = param_q[i];
    end
  end

  assign sel_idx   = sel_q;
  assign sel_valid = (sel_q < SEL_W'(NUM_DEV));
  assign sel_pol   = pick_bit(pol_vec, sel_q);
  assign sel_pha   = pick_bit(pha_vec, sel_q);

endmodule

// File: rtl/spi_tgen_phase.sv
module spi_tgen_phase
  import spi_tgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [FLD_W-1:0] step,
  output logic             tick
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum  = {1'b0, acc_q} + (ACC_W+1)'(step);
  assign tick = run && sum[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (run) acc_q <= sum[ACC_W-1:0];
    else          acc_q <= '0;
  end

endmodule

// File: rtl/spi_tgen_seq.sv
module spi_tgen_seq
  import spi_tgen_pkg::*;
#(
  parameter int NUM_DEV = 5,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   nbits,
  input  dev_param_t         sel_param,
  input  logic [SEL_W-1:0]   sel_idx,
  input  logic               sel_valid,
  input  logic               sel_pol,
  input  logic               sel_pha,
  input  logic               tick,
  output logic               run,
  output logic [FLD_W-1:0]   step,
  output logic               accept,
  output logic               busy,
  output logic               done,
  output logic               sclk,
  output logic               sclk_en,
  output logic               sample_stb,
  output logic               shift_stb,
  output logic [NUM_DEV-1:0] cs_n
);

  localparam int HC_W = CNT_W + 1;

  tgen_state_e       st_q;
  logic [FLD_W-1:0]  cnt_q, step_q, hold_q, gap_q;
  logic [SEL_W-1:0]  dev_q;
  logic [CNT_W-1:0]  nbits_q;
  logic [HC_W-1:0]   hcnt_q;
  logic              pol_q, pha_q, ph_q;
  logic              samp_q, shft_q, done_q;
  logic              last_half, leading, in_frame;

  assign accept    = start && (st_q == ST_IDLE) && sel_valid;
  assign last_half = (hcnt_q == HC_W'(({1'b0, nbits_q} << 1) - HC_W'(1)));
  assign leading   = !ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      step_q  <= FLD_W'(1);
      hold_q  <= '0;
      gap_q   <= '0;
      dev_q   <= '0;
      nbits_q <= '0;
      hcnt_q  <= '0;
      pol_q   <= 1'b0;
      pha_q   <= 1'b0;
      ph_q    <= 1'b0;
      samp_q  <= 1'b0;
      shft_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      samp_q <= 1'b0;
      shft_q <= 1'b0;
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q    <= ST_SETUP;
            cnt_q   <= sel_param.setup;
            step_q  <= pow2_floor(sel_param.rate);
            hold_q  <= sel_param.hold;
            gap_q   <= sel_param.gap;
            dev_q   <= sel_idx;
            pol_q   <= sel_pol;
            pha_q   <= sel_pha;
            nbits_q <= nbits;
          end
        end
        ST_SETUP: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - FLD_W'(1);
          end else if (nbits_q == '0) begin
            st_q  <= ST_HOLD;
            cnt_q <= hold_q;
          end else begin
            st_q   <= ST_ACTIVE;
            hcnt_q <= '0;
          end
        end
        ST_ACTIVE: begin
          if (tick) begin
            ph_q   <= !ph_q;
            samp_q <= (leading != pha_q);
            shft_q <= (leading == pha_q);
            hcnt_q <= hcnt_q + HC_W'(1);
            if (last_half) begin
              st_q  <= ST_HOLD;
              cnt_q <= hold_q;
            end
          end
        end
        ST_HOLD: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - FLD_W'(1);
          end else begin
            st_q  <= ST_GAP;
            cnt_q <= gap_q;
          end
        end
        ST_GAP: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - FLD_W'(1);
          end else begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_frame = (st_q == ST_SETUP) || (st_q == ST_ACTIVE) || (st_q == ST_HOLD);

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_cs
    assign cs_n[i] = !(in_frame && (dev_q == SEL_W'(i)));
  end

  assign run        = (st_q == ST_ACTIVE);
  assign step       = step_q;
  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign sclk_en    = run;
  assign sample_stb = samp_q;
  assign shift_stb  = shft_q;
  assign sclk       = ((st_q == ST_IDLE) ? sel_pol : pol_q) ^ ph_q;

endmodule

// File: rtl/spi_tgen.sv
module spi_tgen
  import spi_tgen_pkg::*;
#(
  parameter int NUM_DEV = 5,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               start,
  input  logic [CNT_W-1:0]   nbits,
  output logic               busy,
  output logic               done,
  output logic               sclk,
  output logic               sclk_en,
  output logic               sample_stb,
  output logic               shift_stb,
  output logic [NUM_DEV-1:0] cs_n
);

  dev_param_t        sel_param;
  logic [SEL_W-1:0]  sel_idx;
  logic              sel_valid;
  logic              idle_pol;
  logic              sel_pha;
  logic              half_tick;
  logic              run;
  logic              accept;
  logic [FLD_W-1:0]  step;

  spi_tgen_regs #(.NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sel_param (sel_param),
    .sel_idx   (sel_idx),
    .sel_valid (sel_valid),
    .sel_pol   (idle_pol),
    .sel_pha   (sel_pha)
  );

  spi_tgen_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .step  (step),
    .tick  (half_tick)
  );

  spi_tgen_seq #(.NUM_DEV(NUM_DEV), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .nbits      (nbits),
    .sel_param  (sel_param),
    .sel_idx    (sel_idx),
    .sel_valid  (sel_valid),
    .sel_pol    (idle_pol),
    .sel_pha    (sel_pha),
    .tick       (half_tick),
    .run        (run),
    .step       (step),
    .accept     (accept),
    .busy       (busy),
    .done       (done),
    .sclk       (sclk),
    .sclk_en    (sclk_en),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb),
    .cs_n       (cs_n)
  );

endmodule

// File: rtl/spi_tgen_chk.sv
module spi_tgen_chk #(
  parameter int NUM_DEV = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               accept,
  input logic               busy,
  input logic               done,
  input logic               sclk,
  input logic               sclk_en,
  input logic               sample_stb,
  input logic               shift_stb,
  input logic               half_tick,
  input logic               idle_pol,
  input logic [NUM_DEV-1:0] cs_n
);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1) else $error("cs_n not one-hot"); // R5

  AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n)) else $error("cs_n low while idle"); // R5

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == idle_pol)) else $error("idle sclk level"); // R3

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && shift_stb)) else $error("both strobes"); // R8

  AST_STB_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || shift_stb) |-> (sclk != $past(sclk))) else $error("strobe without edge"); // R8

  AST_EN_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_en |-> !(&cs_n)) else $error("clocking outside frame"); // R7

  AST_TICK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> sclk_en) else $error("tick outside clocking"); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done wider than one cycle"); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && (&cs_n))) else $error("done while framed"); // R10

  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |-> !accept) else $error("start taken while busy"); // R4

endmodule

bind spi_tgen spi_tgen_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .accept     (accept),
  .busy       (busy),
  .done       (done),
  .sclk       (sclk),
  .sclk_en    (sclk_en),
  .sample_stb (sample_stb),
  .shift_stb  (shift_stb),
  .half_tick  (half_tick),
  .idle_pol   (idle_pol),
  .cs_n       (cs_n)
);

// File: tb/spi_tgen_tb.sv
module spi_tgen_tb;

  localparam int ND = 5;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int PORT = 4 * ND;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          start = 1'b0;
  logic [CW-1:0] nbits = '0;
  logic          busy, done, sclk, sclk_en, sample_stb, shift_stb;
  logic [ND-1:0] cs_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  spi_tgen #(.NUM_DEV(ND), .ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .nbits(nbits), .busy(busy), .done(done), .sclk(sclk),
    .sclk_en(sclk_en), .sample_stb(sample_stb), .shift_stb(shift_stb), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_xfer(input int dev, input int rate, input int s, input int hd, input int d,
                          input int n, input int pol, input int pha, input bit load, input bit reissue);
    int p, h, e_first, e_rise, e_done;
    int c, tog, first, last, rise, done_c, busy_drop, en_cnt;
    int s_lead, s_trail, h_lead, h_trail, bad_stb, bad_ivl, other_bad;
    logic prev;
    logic [ND-1:0] mask;
    if (load) wr_reg(4 * dev, {8'(rate), 8'(s), 8'(hd), 8'(d)});
    wr_reg(PORT, (32'(dev) << 20) | (32'(pol) << (19 - dev)) | (32'(pha) << (14 - dev)));
    chk(sclk === 1'(pol), "R3 idle sclk level", int'(sclk), pol);
    p = 1;
    while (p * 2 <= rate) p = p * 2;
    h = 256 / p;
    e_first = s + 2 + h;
    e_rise  = s + 2 * n * h + hd + 3;
    e_done  = e_rise + d + 1;
    tog = 0; first = -1; last = 0; rise = -1; done_c = -1; busy_drop = -1; en_cnt = 0;
    s_lead = 0; s_trail = 0; h_lead = 0; h_trail = 0; bad_stb = 0; bad_ivl = 0; other_bad = 0;
    mask = ND'(1) << dev;
    prev = sclk;
    @(negedge clk);
    start = 1'b1; nbits = CW'(n);
    @(negedge clk);
    start = 1'b0;
    c = 1;
    chk(cs_n === ~mask, "R5 chip select in cycle 1", int'(cs_n), int'(~mask));
    while (done_c < 0 && c < e_done + 40) begin
      start = (reissue && c == s + 3);
      if (sclk !== prev) begin
        tog++;
        if (tog > 1 && (c - last) != h) bad_ivl++;
        if (tog == 1) first = c;
        last = c;
      end
      if (sample_stb) begin
        if (sclk === prev) bad_stb++;
        else if (tog % 2 == 1) s_lead++;
        else s_trail++;
      end
      if (shift_stb) begin
        if (sclk === prev) bad_stb++;
        else if (tog % 2 == 1) h_lead++;
        else h_trail++;
      end
      prev = sclk;
      if (sclk_en) en_cnt++;
      if (rise < 0 && cs_n[dev]) rise = c;
      if ((cs_n | mask) !== '1) other_bad++;
      if (busy_drop < 0 && !busy) busy_drop = c;
      if (done) done_c = c;
      @(negedge clk);
      c++;
    end
    start = 1'b0;
    if (n > 0) chk(first == e_first, "R6 first toggle cycle", first, e_first);
    chk(tog == 2 * n, (n == 0) ? "R11 no toggles" : "R7 toggle count", tog, 2 * n);
    chk(en_cnt == 2 * n * h, "R7 sclk_en cycles", en_cnt, 2 * n * h);
    chk(bad_ivl == 0, "R2 half period", bad_ivl, 0);
    chk(s_lead == (pha ? 0 : n) && s_trail == (pha ? n : 0), "R8 sample strobes",
        s_lead * 1000 + s_trail, (pha ? 0 : n) * 1000 + (pha ? n : 0));
    chk(h_lead == (pha ? n : 0) && h_trail == (pha ? 0 : n) && bad_stb == 0, "R8 shift strobes",
        h_lead * 1000 + h_trail + bad_stb * 1000000, (pha ? n : 0) * 1000 + (pha ? 0 : n));
    chk(other_bad == 0, "R5 other selects high", other_bad, 0);
    chk(rise == e_rise, (n == 0) ? "R11 select release" : "R9 select release", rise, e_rise);
    chk(done_c == e_done, "R10 done cycle", done_c, e_done);
    chk(busy_drop == e_done, "R10 busy drop", busy_drop, e_done);
    chk(done === 1'b0, "R10 done one cycle", int'(done), 0);
    chk(sclk === 1'(pol), "R3 level after transfer", int'(sclk), pol);
    if (reissue) begin
      for (int k = 0; k < 6; k++) begin
        if (busy !== 1'b0 || cs_n !== '1) other_bad++;
        @(negedge clk);
      end
      chk(other_bad == 0, "R4 start while busy ignored", other_bad, 0);
    end
  endtask

  initial begin
    wait (cyc >= 190000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n === '1 && busy === 1'b0 && done === 1'b0 && sclk === 1'b0 && sclk_en === 1'b0,
        "R5 reset state", int'(cs_n), (1 << ND) - 1);

    // R1: distinct words for every device, then each device from its own word
    for (int dv = 0; dv < ND; dv++)
      wr_reg(4 * dv, {8'(1 << (3 + dv % 3)), 8'(dv), 8'(dv + 1), 8'(2 * dv)});
    for (int dv = 0; dv < ND; dv++)
      for (int m = 0; m < 4; m++)
        run_xfer(dv, 1 << (3 + dv % 3), dv, dv + 1, 2 * dv, 1 + m, m % 2, m / 2, 1'b0, 1'b0);

    // R2: every rate field value
    for (int f = 0; f < 256; f++)
      run_xfer(f % ND, f, 1, 2, 3, 1, (f >> 1) % 2, (f >> 2) % 2, 1'b1, 1'b0);

    // R6 R9 R10: count extremes
    run_xfer(2, 128, 0, 0, 0, 3, 1, 1, 1'b1, 1'b0);
    run_xfer(3, 128, 255, 255, 255, 2, 0, 1, 1'b1, 1'b0);
    // R11: zero-length transfer
    run_xfer(1, 64, 4, 5, 6, 0, 1, 0, 1'b1, 1'b0);
    // R4: start while busy
    run_xfer(4, 32, 2, 3, 4, 4, 0, 0, 1'b1, 1'b1);

    // R4: invalid device select
    for (int sv = ND; sv < 8; sv++) begin
      wr_reg(PORT, 32'(sv) << 20);
      @(negedge clk); start = 1'b1; nbits = 8'd2;
      @(negedge clk); start = 1'b0;
      bad = 0;
      for (int k = 0; k < 30; k++) begin
        if (busy !== 1'b0 || done !== 1'b0 || cs_n !== '1 || sclk_en !== 1'b0) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R4 invalid select ignored", bad, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule